// File: doc/BRIEF.md
# SAR ADC Sequencing Controller

This block is the digital sequencer for an 8-bit successive-approximation converter that has eight multiplexed analog inputs. A start request captures three settings: a channel number, a prescaler code and a phase-halving select. The block then steers the external multiplexer to that channel and closes the sample switch. Next it runs the binary search, one bit per slot. In each slot it drives a trial code to the external DAC and reads the single comparator bit back. The multiplexer, DAC and comparator are outside the block.

All timing is counted in conversion-clock periods, which come from an internal prescaler. One conversion always lasts 160 periods: 12 for sampling, eight equal bit slots of 18 periods each, and 4 periods of settling before the result is latched. The finished code leaves the block on a valid/ready output. The valid flag stays high, and the data holds, until the consumer accepts the result by seeing `res_ready` high while `res_valid` is high. If a newer result lands while an older one is still unaccepted, the newer one overwrites it. The consumer can stall forever without stalling conversions, and every accepted word is the most recent result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `res_valid`, `sample_en` and `dac_code` are all zero.
- R2: When `start` is seen while `busy` is low:
  - `chan_sel` is captured onto `mux_sel` and `busy` rises.
  - `sample_en` is then high for exactly 12 conversion-clock periods.
  - `dac_code` is 0 while sampling.
- R3: One conversion-clock period lasts the following number of system clocks:
  - With `phase_half`=1: 2, 4 or 16 for `pre_code` 00, 01 or 11.
  - With `phase_half`=0: 1, 2 or 8 for the same codes.
  - `busy` stays high for exactly 160 conversion-clock periods.
- R4: `pre_code` 10 gives the same period as code 11.
- R5: The search tests the MSB first. The first trial code after sampling is 80h and it is held for one 18-period slot. A bit is kept when `cmp_hi` is 1 (input at or above the trial level) at the end of its slot.
- R6: The result equals the input level seen by an ideal comparator. An input of zero gives 00h and full scale gives FFh.
- R7: A `start` that arrives while `busy` is high is ignored. The channel, the timing and the result stay those of the running conversion.
- R8: `busy` stays high until the result register is updated. `res_valid` is high in the cycle after `busy` falls.
- R9: `res_valid` and `res_data` hold until `res_ready` is seen high while `res_valid` is high. After that, `res_valid` reads 0.
- R10: If a new result is latched in the same cycle that the consumer accepts the old one, `res_valid` stays high and carries the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request, honoured only when idle |
| chan_sel | input | 3 | Channel to convert |
| phase_half | input | 1 | 1: prescaler runs from the halved system phase |
| pre_code | input | 2 | Prescaler code (00, 01, 11; 10 acts as 11) |
| busy | output | 1 | Conversion in progress |
| mux_sel | output | 3 | Analog multiplexer select |
| sample_en | output | 1 | Sample switch closed |
| dac_code | output | 8 | Trial code for the external DAC |
| cmp_hi | input | 1 | Comparator: input at or above trial level |
| res_data | output | 8 | Conversion result |
| res_valid | output | 1 | Result available (sticky) |
| res_ready | input | 1 | Consumer accepts the result |

## Verification
Two events can fall in the same cycle: a conversion latching its result, and the consumer accepting the previous one. The bench provokes this by leaving a result unaccepted, starting a second conversion, and raising `res_ready` in exactly the last cycle of that conversion. The cycle is known in advance, because the conversion runs a fixed 160 periods of one system clock each. The bench then expects `res_valid` to remain high with the second code. It also expects the first code to have held through the whole second conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_BITS   = 2'd2,
    PH_SETTLE = 2'd3
  } phase_e;

  // largest log2 divisor: code 11 (or 10) with the halved phase
  localparam int MAX_SHIFT = 4;
  localparam int SHIFT_W   = 3;

  // log2 of system clocks per conversion clock
  function automatic logic [SHIFT_W-1:0] div_shift(input logic half,
                                                   input logic [1:0] code);
    logic [SHIFT_W-1:0] base;
    case (code)
      2'b00:   base = 3'd0;
      2'b01:   base = 3'd1;
      default: base = 3'd3;
    endcase
    return base + {2'b00, half};
  endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = MAX_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SHIFT_W-1:0] shift_in,
  input  logic               run,
  output logic               tick
);

  logic [SHIFT_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   lim;

  assign lim  = CNT_W'((32'd1 << shift_q) - 32'd1);
  assign tick = run && !load && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      shift_q <= shift_in;
      cnt_q   <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS     = 8,
  parameter int SAMPLE_TICKS = 12,
  parameter int SLOT_TICKS   = 18,
  parameter int SETTLE_TICKS = 4,
  localparam int BIT_W       = $clog2(RES_BITS),
  localparam int TMAX        = (SAMPLE_TICKS > SLOT_TICKS) ?
                               ((SAMPLE_TICKS > SETTLE_TICKS) ? SAMPLE_TICKS : SETTLE_TICKS) :
                               ((SLOT_TICKS > SETTLE_TICKS) ? SLOT_TICKS : SETTLE_TICKS),
  localparam int TC_W        = $clog2(TMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  output phase_e           phase,
  output logic [BIT_W-1:0] bit_idx,
  output logic             enter_bits,
  output logic             slot_end,
  output logic             finish
);

  localparam bit HAS_SETTLE  = (SETTLE_TICKS > 0);
  localparam int SETTLE_LAST = HAS_SETTLE ? SETTLE_TICKS - 1 : 0;

  logic [TC_W-1:0] tcnt;
  logic            last_bit;

  always_comb begin
    last_bit   = (bit_idx == '0);
    enter_bits = tick && (phase == PH_SAMPLE) && (tcnt == TC_W'(SAMPLE_TICKS - 1));
    slot_end   = tick && (phase == PH_BITS) && (tcnt == TC_W'(SLOT_TICKS - 1));
    finish     = (slot_end && last_bit && !HAS_SETTLE) ||
                 (tick && (phase == PH_SETTLE) && (tcnt == TC_W'(SETTLE_LAST)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      tcnt    <= '0;
      bit_idx <= '0;
    end else if (go) begin
      phase <= PH_SAMPLE;
      tcnt  <= '0;
    end else if (tick) begin
      case (phase)
        PH_SAMPLE: begin
          if (enter_bits) begin
            phase   <= PH_BITS;
            bit_idx <= BIT_W'(RES_BITS - 1);
            tcnt    <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PH_BITS: begin
          if (slot_end) begin
            tcnt <= '0;
            if (last_bit) phase <= HAS_SETTLE ? PH_SETTLE : PH_IDLE;
            else          bit_idx <= bit_idx - 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PH_SETTLE: begin
          if (finish) begin
            phase <= PH_IDLE;
            tcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int RES_BITS = 8,
  localparam int BIT_W   = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                enter,
  input  logic                decide,
  input  logic [BIT_W-1:0]    bit_idx,
  input  logic                keep,
  output logic [RES_BITS-1:0] trial,
  output logic [RES_BITS-1:0] resolved
);

  // decision for the current bit, plus the trial bit for the next one
  always_comb begin
    resolved = trial;
    if (decide) begin
      if (!keep) resolved[bit_idx] = 1'b0;
      if (bit_idx != '0) resolved[bit_idx - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      trial <= '0;
    else if (clear)  trial <= '0;
    else if (enter)  trial <= {1'b1, {(RES_BITS-1){1'b0}}};
    else if (decide) trial <= resolved;
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS     = 8,
  parameter int CH_NUM       = 8,
  parameter int TOTAL_TICKS  = 160,
  parameter int SAMPLE_TICKS = 12,
  localparam int CH_W        = $clog2(CH_NUM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CH_W-1:0]     chan_sel,
  input  logic                phase_half,
  input  logic [1:0]          pre_code,
  output logic                busy,
  output logic [CH_W-1:0]     mux_sel,
  output logic                sample_en,
  output logic [RES_BITS-1:0] dac_code,
  input  logic                cmp_hi,
  output logic [RES_BITS-1:0] res_data,
  output logic                res_valid,
  input  logic                res_ready
);

  localparam int SLOT_TICKS   = (TOTAL_TICKS - SAMPLE_TICKS) / RES_BITS;
  localparam int SETTLE_TICKS = TOTAL_TICKS - SAMPLE_TICKS - SLOT_TICKS * RES_BITS;
  localparam int BIT_W        = $clog2(RES_BITS);

  phase_e              phase;
  logic [BIT_W-1:0]    bit_idx;
  logic                go, tick, enter_bits, slot_end, finish;
  logic [RES_BITS-1:0] trial, resolved;

  assign go = start && !busy;

  adc_prescaler #(.CNT_W(MAX_SHIFT)) i_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go),
    .shift_in (div_shift(phase_half, pre_code)),
    .run      (busy),
    .tick     (tick)
  );

  adc_phase_seq #(
    .RES_BITS     (RES_BITS),
    .SAMPLE_TICKS (SAMPLE_TICKS),
    .SLOT_TICKS   (SLOT_TICKS),
    .SETTLE_TICKS (SETTLE_TICKS)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .tick       (tick),
    .phase      (phase),
    .bit_idx    (bit_idx),
    .enter_bits (enter_bits),
    .slot_end   (slot_end),
    .finish     (finish)
  );

  adc_sar_reg #(.RES_BITS(RES_BITS)) i_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (go),
    .enter    (enter_bits),
    .decide   (slot_end),
    .bit_idx  (bit_idx),
    .keep     (cmp_hi),
    .trial    (trial),
    .resolved (resolved)
  );

  assign sample_en = (phase == PH_SAMPLE);
  assign dac_code  = trial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mux_sel   <= '0;
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      if (go) begin
        busy    <= 1'b1;
        mux_sel <= chan_sel;
      end else if (finish) begin
        busy <= 1'b0;
      end
      if (finish) begin
        res_data  <= resolved;
        res_valid <= 1'b1;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int RES_BITS = 8,
  parameter int CH_W     = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic [CH_W-1:0]     mux_sel,
  input logic                sample_en,
  input logic [RES_BITS-1:0] dac_code,
  input logic [RES_BITS-1:0] res_data,
  input logic                res_valid,
  input logic                res_ready
);

  a_r8_valid_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid);

  a_r2_sample_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> busy);

  a_r2_dac_zero_sampling: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (dac_code == '0));

  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid);

  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> ($stable(res_data) || $fell(busy)));

  a_r7_mux_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(mux_sel)));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_BITS(RES_BITS), .CH_W(CH_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .mux_sel   (mux_sel),
  .sample_en (sample_en),
  .dac_code  (dac_code),
  .res_data  (res_data),
  .res_valid (res_valid),
  .res_ready (res_ready)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, phase_half = 1'b0, res_ready = 1'b0;
  logic [2:0] chan_sel = '0;
  logic [1:0] pre_code = '0;
  logic       busy, sample_en, res_valid, cmp_hi;
  logic [2:0] mux_sel;
  logic [7:0] dac_code, res_data;
  logic [7:0] vin [8];

  int errors = 0, checks = 0;
  logic [7:0] exp_q [$];
  logic [7:0] mon_exp;
  bit mon_en = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;

  // ideal comparator on the selected channel
  assign cmp_hi = (vin[mux_sel] >= dac_code);

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .phase_half(phase_half), .pre_code(pre_code), .busy(busy), .mux_sel(mux_sel),
    .sample_en(sample_en), .dac_code(dac_code), .cmp_hi(cmp_hi),
    .res_data(res_data), .res_valid(res_valid), .res_ready(res_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard monitor: a handshake happens at the next edge
  always @(negedge clk) begin
    if (mon_en && rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected result", res_data, 0);
      end else begin
        mon_exp = exp_q.pop_front();
        check(res_data == mon_exp, "R6 result", res_data, mon_exp);
      end
    end
  end

  // driver: start one conversion and measure its timing at the ports
  task automatic run_conv(input logic [2:0] ch, input logic h, input logic [1:0] pc,
                          input int div, input bit poke, input string tag);
    int  n_busy = 0, n_samp = 0, n80 = 0;
    bit  mux_ok = 1'b1;
    @(negedge clk);
    chan_sel = ch; phase_half = h; pre_code = pc; start = 1'b1;
    if (mon_en) exp_q.push_back(vin[ch]);
    @(negedge clk);
    start = 1'b0;
    while (busy) begin
      n_busy++;
      if (sample_en) n_samp++;
      else if (dac_code == 8'h80) n80++;
      if (mux_sel != ch) mux_ok = 1'b0;
      if (poke && n_busy == 20) begin
        start = 1'b1; chan_sel = ch ^ 3'd5; phase_half = ~h; pre_code = ~pc;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(n_busy == 160 * div, {tag, " R3 busy length"}, n_busy, 160 * div);
    check(n_samp == 12 * div, {tag, " R2 sample length"}, n_samp, 12 * div);
    check(n80 == 18 * div, {tag, " R5 MSB trial slot"}, n80, 18 * div);
    check(mux_ok, {tag, " R2 R7 channel held"}, mux_ok, 1);
    check(res_valid == 1'b1, {tag, " R8 valid after busy"}, res_valid, 1);
  endtask

  initial begin
    vin[0] = 8'h00; vin[1] = 8'h37; vin[2] = 8'h5A; vin[3] = 8'hA5;
    vin[4] = 8'hFF; vin[5] = 8'h12; vin[6] = 8'hC3; vin[7] = 8'h7E;
    repeat (3) @(negedge clk);
    check(!busy && !res_valid && !sample_en && dac_code == 0, "R1 in reset",
          {busy, res_valid, sample_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !res_valid && !sample_en && dac_code == 0, "R1 after reset",
          dac_code, 0);

    mon_en = 1'b1; res_ready = 1'b1;
    run_conv(3'd3, 1'b0, 2'b00, 1,  1'b0, "R3 direct/00");
    run_conv(3'd6, 1'b1, 2'b00, 2,  1'b0, "R3 half/00");
    run_conv(3'd1, 1'b1, 2'b01, 4,  1'b0, "R3 half/01");
    run_conv(3'd5, 1'b1, 2'b11, 16, 1'b0, "R3 half/11");
    run_conv(3'd7, 1'b1, 2'b10, 16, 1'b0, "R4 half/10");
    run_conv(3'd2, 1'b0, 2'b01, 2,  1'b0, "R3 direct/01");
    run_conv(3'd4, 1'b0, 2'b11, 8,  1'b0, "R6 full scale");
    run_conv(3'd0, 1'b0, 2'b10, 8,  1'b0, "R6 zero R4 direct/10");
    run_conv(3'd3, 1'b1, 2'b00, 2,  1'b1, "R7 start while busy");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);

    // R9: sticky result with no consumer
    mon_en = 1'b0; res_ready = 1'b0;
    vin[6] = 8'h9C;
    run_conv(3'd6, 1'b0, 2'b00, 1, 1'b0, "R9 setup");
    repeat (40) @(negedge clk);
    check(res_valid && res_data == 8'h9C, "R9 held without ready", res_data, 8'h9C);

    // R10: acceptance in the same cycle as a new latch
    vin[2] = 8'h21;
    @(negedge clk);
    chan_sel = 3'd2; phase_half = 1'b0; pre_code = 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (159) @(negedge clk);
    check(busy && res_valid && res_data == 8'h9C, "R9 old data during conversion",
          res_data, 8'h9C);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(!busy && res_valid && res_data == 8'h21, "R10 new result survives accept",
          res_data, 8'h21);
    @(negedge clk);
    check(res_valid == 1'b1, "R10 valid still high", res_valid, 1);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(res_valid == 1'b0, "R9 cleared by accept", res_valid, 0);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
    end
  end

endmodule